// File: doc/BRIEF.md
# Prioritised Two-Output Interrupt Controller

This block gathers 64 level interrupt requests and sends each one to one of two processor inputs. One input is a normal request line that has a priority arbiter behind it. The other is a fast request line that is a plain OR of its sources. Software programs the block through a small word-addressed register port. A full 32-bit word sets enables for 32 sources at once, and two one-shot registers take a source number and set or clear only that source's enable bit. Each source also has a route bit, which chooses the normal or fast line, and a 4-bit priority.

The normal path looks only at sources that are pending, enabled and routed to the normal line. It then drops every source whose priority does not rise above a programmable mask level. Among the sources left, it picks the highest priority. A tie goes to the higher source number. The winner is registered. It drives the normal request line and is readable as a status word. The status word reads as all ones when there is no winner.

Register word addresses (`reg_addr`): 0 mask level, 1 enable-by-number, 2 disable-by-number, 3 enables of sources 0..31, 4 enables of sources 32..63, 5 routes of sources 0..31, 6 routes of sources 32..63, 7 winner status, 8..15 priority words.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all enable, route and priority bits read 0. The mask level reads 0x1F. Both request outputs are low, and the status word at address 7 reads 0xFFFFFFFF.
- R2: Address 3 holds the enables of sources 0..31 and address 4 holds those of sources 32..63, with bit i of the word for source i (or 32+i). Both words can be written and read back whole.
- R3: A write to address 1 sets the enable of the source numbered by `reg_wdata[5:0]`. All other enable bits are unchanged.
- R4: A write to address 2 clears the enable of the source numbered by `reg_wdata[5:0]`. All other enable bits are unchanged.
- R5: Address 5 holds the route bits of sources 0..31 and address 6 those of sources 32..63. A route bit of 1 sends the source to `irq_fast_o`, and 0 sends it to the normal path.
- R6: Priority word 8+k holds sources 8k..8k+7. Source 8k+j sits in bits 4j+3:4j. Value 15 is the highest priority and 0 the lowest.
- R7: The mask level at address 0 is 5 bits wide. When bit 4 is set, no source is masked. When bit 4 is clear, normal sources whose priority is less than or equal to bits 3:0 are excluded.
- R8: The status word at address 7 gives the number of the winning normal source, zero-extended. The winner has the highest priority among the pending, enabled, normal-routed and unmasked sources. A tie goes to the higher number. The word is 0xFFFFFFFF when no source qualifies.
- R9: `irq_norm_o` is high exactly when a winner exists. `irq_fast_o` is high exactly when some pending, enabled source has route bit 1. Both are levels that stay high as long as the condition holds.
- R10: Source levels and register writes are captured at a clock edge. Their effect shows on the outputs and on the status word after the next edge. A write and a source change captured at the same edge both take effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| src_i | input | 64 | Interrupt request levels, bit n for source n |
| irq_norm_o | output | 1 | Normal request, prioritised and masked |
| irq_fast_o | output | 1 | Fast request |

## Verification
The hard overlap is a configuration write landing in the same cycle as a change on the request inputs. Examples are an enable-by-number write for a source that rises in the same cycle, and a mask, route or priority write while the current winner drops. The bench forces this overlap both on purpose and through a long stretch of random writes mixed with random request patterns. A behavioural model takes its decision at each edge from the state before the write, then applies the write and the new levels. Outputs and status are compared with that model on every clock, so a design that uses the new configuration one edge too early or too late shows up as a mismatch.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NUM_SRC = 64;
  localparam int PRIO_W  = 4;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int ID_W    = $clog2(NUM_SRC);
  localparam int MASK_W  = PRIO_W + 1;
  localparam int EN_WORDS   = NUM_SRC / WORD_W;
  localparam int PRIO_WORDS = (NUM_SRC * PRIO_W) / WORD_W;
  localparam int PW_IDX_W   = $clog2(PRIO_WORDS);

  localparam logic [ADDR_W-1:0] RA_MASK   = 4'd0;
  localparam logic [ADDR_W-1:0] RA_EN_SET = 4'd1;
  localparam logic [ADDR_W-1:0] RA_EN_CLR = 4'd2;
  localparam logic [ADDR_W-1:0] RA_EN_LO  = 4'd3;
  localparam logic [ADDR_W-1:0] RA_EN_HI  = 4'd4;
  localparam logic [ADDR_W-1:0] RA_TYP_LO = 4'd5;
  localparam logic [ADDR_W-1:0] RA_TYP_HI = 4'd6;
  localparam logic [ADDR_W-1:0] RA_STATUS = 4'd7;

  typedef struct packed {
    logic              valid;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   id;
  } cand_t;
endpackage

// File: rtl/irq_vec_rst_sync.sv
module irq_vec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
  import irq_vec_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [WORD_W-1:0]          wdata,
  input  logic                       stat_valid,
  input  logic [ID_W-1:0]            stat_id,
  output logic [WORD_W-1:0]          rdata,
  output logic [NUM_SRC-1:0]         en_o,
  output logic [NUM_SRC-1:0]         typ_o,
  output logic [NUM_SRC*PRIO_W-1:0]  prio_o,
  output logic [MASK_W-1:0]          mask_o
);
  logic [MASK_W-1:0]         mask_q, mask_d;
  logic [NUM_SRC-1:0]        en_q, en_d;
  logic [NUM_SRC-1:0]        typ_q, typ_d;
  logic [NUM_SRC*PRIO_W-1:0] prio_q, prio_d;
  logic [ID_W-1:0]           num;
  logic [PW_IDX_W-1:0]       pw_sel;

  assign num    = wdata[ID_W-1:0];
  assign pw_sel = addr[PW_IDX_W-1:0];

  // next state
  always_comb begin
    mask_d = mask_q;
    en_d   = en_q;
    typ_d  = typ_q;
    prio_d = prio_q;
    if (addr[ADDR_W-1]) begin
      prio_d[WORD_W*int'(pw_sel) +: WORD_W] = wdata;
    end else begin
      case (addr)
        RA_MASK:   mask_d = wdata[MASK_W-1:0];
        RA_EN_SET: en_d[num] = 1'b1;
        RA_EN_CLR: en_d[num] = 1'b0;
        RA_EN_LO:  en_d[WORD_W-1:0] = wdata;
        RA_EN_HI:  en_d[EN_WORDS*WORD_W-1:WORD_W] = wdata;
        RA_TYP_LO: typ_d[WORD_W-1:0] = wdata;
        RA_TYP_HI: typ_d[EN_WORDS*WORD_W-1:WORD_W] = wdata;
        default:   ;
      endcase
    end
  end

  // registers, clock-enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      en_q   <= '0;
      typ_q  <= '0;
      prio_q <= '0;
    end else if (wr) begin
      mask_q <= mask_d;
      en_q   <= en_d;
      typ_q  <= typ_d;
      prio_q <= prio_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (addr[ADDR_W-1]) begin
      rdata = prio_q[WORD_W*int'(pw_sel) +: WORD_W];
    end else begin
      case (addr)
        RA_MASK:   rdata = WORD_W'(mask_q);
        RA_EN_LO:  rdata = en_q[WORD_W-1:0];
        RA_EN_HI:  rdata = en_q[EN_WORDS*WORD_W-1:WORD_W];
        RA_TYP_LO: rdata = typ_q[WORD_W-1:0];
        RA_TYP_HI: rdata = typ_q[EN_WORDS*WORD_W-1:WORD_W];
        RA_STATUS: rdata = stat_valid ? WORD_W'(stat_id) : '1;
        default:   rdata = '0;
      endcase
    end
  end

  assign en_o   = en_q;
  assign typ_o  = typ_q;
  assign prio_o = prio_q;
  assign mask_o = mask_q;

  // R3: set-by-number raises the addressed bit
  assert_set_num_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == RA_EN_SET) |=> en_q[$past(num)]);

  // R3 and R4: a by-number write flips at most one enable bit
  assert_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (addr == RA_EN_SET || addr == RA_EN_CLR)) |=> ($countones(en_q ^ $past(en_q)) <= 1));

  // R4: clear-by-number drops the addressed bit
  assert_clr_num_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == RA_EN_CLR) |=> !en_q[$past(num)]);
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb
  import irq_vec_pkg::*;
(
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC-1:0]        en,
  input  logic [NUM_SRC-1:0]        typ,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  input  logic [MASK_W-1:0]         mask,
  output logic                      win_valid,
  output logic [ID_W-1:0]           win_id,
  output logic                      fast_any
);
  localparam int NODES = 2*NUM_SRC - 1;

  cand_t node [NODES];

  // leaves: heap slots NUM_SRC-1 .. 2*NUM_SRC-2, ascending source number
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_leaf
    logic [PRIO_W-1:0] p;
    logic              pass;
    assign p    = prio[i*PRIO_W +: PRIO_W];
    assign pass = mask[MASK_W-1] | (p > mask[PRIO_W-1:0]);
    assign node[NUM_SRC-1+i] = {pend[i] & en[i] & ~typ[i] & pass, p, ID_W'(i)};
  end

  // inner nodes: right child holds the higher numbers and wins ties
  for (genvar j = 0; j < NUM_SRC-1; j++) begin : g_node
    logic take_r;
    assign take_r = node[2*j+2].valid &
                    (~node[2*j+1].valid | (node[2*j+2].prio >= node[2*j+1].prio));
    assign node[j] = take_r ? node[2*j+2] : node[2*j+1];
  end

  assign win_valid = node[0].valid;
  assign win_id    = node[0].id;
  assign fast_any  = |(pend & en & typ);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic [NUM_SRC-1:0]  src_i,
  output logic                irq_norm_o,
  output logic                irq_fast_o
);
  logic                      rst_ns;
  logic [NUM_SRC-1:0]        pend_q, pend_d;
  logic [NUM_SRC-1:0]        en_v, typ_v;
  logic [NUM_SRC*PRIO_W-1:0] prio_v;
  logic [MASK_W-1:0]         mask_v;
  logic                      win_valid, fast_any;
  logic [ID_W-1:0]           win_id;
  logic                      norm_q, norm_d, fast_q, fast_d;
  logic [ID_W-1:0]           wid_q, wid_d;

  irq_vec_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  irq_vec_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_ns),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .stat_valid (norm_q),
    .stat_id    (wid_q),
    .rdata      (reg_rdata),
    .en_o       (en_v),
    .typ_o      (typ_v),
    .prio_o     (prio_v),
    .mask_o     (mask_v)
  );

  irq_vec_arb u_arb (
    .pend      (pend_q),
    .en        (en_v),
    .typ       (typ_v),
    .prio      (prio_v),
    .mask      (mask_v),
    .win_valid (win_valid),
    .win_id    (win_id),
    .fast_any  (fast_any)
  );

  always_comb begin
    pend_d = src_i;
    norm_d = win_valid;
    fast_d = fast_any;
    wid_d  = win_valid ? win_id : '0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      pend_q <= '0;
      norm_q <= 1'b0;
      fast_q <= 1'b0;
      wid_q  <= '0;
    end else begin
      pend_q <= pend_d;
      norm_q <= norm_d;
      fast_q <= fast_d;
      wid_q  <= wid_d;
    end
  end

  assign irq_norm_o = norm_q;
  assign irq_fast_o = fast_q;

  // R8: the arbiter only names a pending, enabled, normal-routed source
  assert_win_qual_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    win_valid |-> (pend_q[win_id] && en_v[win_id] && !typ_v[win_id]));

  // R7: the winner always clears the mask level
  assert_win_mask_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    win_valid |-> (mask_v[MASK_W-1] || (prio_v[int'(win_id)*PRIO_W +: PRIO_W] > mask_v[PRIO_W-1:0])));

  // R9: a qualifying fast source raises the fast line on the next edge
  assert_fast_level_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (|(pend_q & en_v & typ_v)) |=> irq_fast_o);
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [63:0] src_i;
  logic        irq_norm_o, irq_fast_o;

  always #5 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_i(src_i),
    .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
  );

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;
  int cycles = 0;

  // behavioural reference
  bit en_m [64];
  bit typ_m [64];
  int pr_m [64];
  bit pend_m [64];
  int mask_m;
  bit exp_norm, exp_fast;
  int exp_win;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return (exp_win < 0) ? 32'hFFFF_FFFF : 32'(exp_win);
  endfunction

  function automatic logic [31:0] en_word(input int k);
    logic [31:0] w = '0;
    for (int i = 0; i < 32; i++) w[i] = en_m[32*k+i];
    return w;
  endfunction

  function automatic logic [31:0] typ_word(input int k);
    logic [31:0] w = '0;
    for (int i = 0; i < 32; i++) w[i] = typ_m[32*k+i];
    return w;
  endfunction

  function automatic logic [31:0] pr_word(input int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 8; j++) w[4*j +: 4] = 4'(pr_m[8*k+j]);
    return w;
  endfunction

  always @(posedge clk) begin : model
    int best;
    int win;
    bit f;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin
        en_m[i] = 0; typ_m[i] = 0; pr_m[i] = 0; pend_m[i] = 0;
      end
      mask_m = 31; exp_norm = 0; exp_fast = 0; exp_win = -1;
    end else begin
      best = -1; win = -1; f = 0;
      for (int i = 0; i < 64; i++) begin
        if (pend_m[i] && en_m[i]) begin
          if (typ_m[i]) f = 1;
          else if ((mask_m >= 16 || pr_m[i] > mask_m) && pr_m[i] >= best) begin
            best = pr_m[i]; win = i;
          end
        end
      end
      exp_fast = f; exp_win = win; exp_norm = (win >= 0);
      if (reg_wr) begin
        case (int'(reg_addr))
          0: mask_m = int'(reg_wdata[4:0]);
          1: en_m[reg_wdata[5:0]] = 1;
          2: en_m[reg_wdata[5:0]] = 0;
          3: for (int i = 0; i < 32; i++) en_m[i] = reg_wdata[i];
          4: for (int i = 0; i < 32; i++) en_m[32+i] = reg_wdata[i];
          5: for (int i = 0; i < 32; i++) typ_m[i] = reg_wdata[i];
          6: for (int i = 0; i < 32; i++) typ_m[32+i] = reg_wdata[i];
          7: ;
          default:
            for (int j = 0; j < 8; j++)
              pr_m[(int'(reg_addr)-8)*8+j] = int'(reg_wdata[4*j +: 4]);
        endcase
      end
      for (int i = 0; i < 64; i++) pend_m[i] = src_i[i];
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (started && !done) begin
      check("R9 normal line", irq_norm_o, exp_norm);
      check("R9 fast line", irq_fast_o, exp_fast);
      if (reg_addr == 4'd7 && !reg_wr) check("R8 status", reg_rdata, exp_status());
    end
  end

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 4'd7; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    #2 reg_addr = a;
    #1 check(req, reg_rdata, exp);
    reg_addr = 4'd7;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 4'd7; reg_wdata = '0; src_i = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    started = 1;

    // R1 reset state
    rd_chk("R1 mask", 4'd0, 32'h1F);
    rd_chk("R1 en lo", 4'd3, 32'h0);
    rd_chk("R1 en hi", 4'd4, 32'h0);
    rd_chk("R1 typ lo", 4'd5, 32'h0);
    rd_chk("R1 typ hi", 4'd6, 32'h0);
    rd_chk("R1 prio", 4'd8, 32'h0);
    rd_chk("R1 status", 4'd7, 32'hFFFF_FFFF);
    check("R1 normal low", irq_norm_o, 0);
    check("R1 fast low", irq_fast_o, 0);

    // R6 priority layout
    wr_reg(4'd9, 32'h7654_3210);
    wr_reg(4'd13, 32'hF000_0000);
    rd_chk("R6 prio word 1", 4'd9, 32'h7654_3210);
    rd_chk("R6 prio word 5", 4'd13, 32'hF000_0000);

    // R3 set by number
    wr_reg(4'd1, 32'd9);
    wr_reg(4'd1, 32'd47);
    wr_reg(4'd1, 32'd12);
    rd_chk("R3 en lo", 4'd3, 32'h0000_1200);
    rd_chk("R3 en hi", 4'd4, 32'h0000_8000);

    // R8 highest priority wins
    src_i[9] = 1; src_i[12] = 1;
    idle(3);
    rd_chk("R8 prio 4 over 1", 4'd7, 32'd12);
    src_i[47] = 1;
    idle(3);
    rd_chk("R8 prio 15 wins", 4'd7, 32'd47);
    src_i[47] = 0;

    // R8 tie goes to higher number
    wr_reg(4'd9, 32'h7654_3240);
    idle(2);
    rd_chk("R8 tie higher number", 4'd7, 32'd12);

    // R7 mask
    wr_reg(4'd0, 32'd4);
    idle(2);
    rd_chk("R7 prio equal to mask blocked", 4'd7, 32'hFFFF_FFFF);
    check("R7 normal low when masked", irq_norm_o, 0);
    wr_reg(4'd0, 32'd3);
    idle(2);
    rd_chk("R7 prio above mask passes", 4'd7, 32'd12);
    wr_reg(4'd0, 32'h10);
    idle(2);
    rd_chk("R7 bit4 disables masking", 4'd7, 32'd12);

    // R5 route to fast
    wr_reg(4'd5, 32'h0000_0200);
    idle(2);
    check("R5 fast line", irq_fast_o, 1);
    rd_chk("R5 fast source not in status", 4'd7, 32'd12);

    // R4 clear by number
    wr_reg(4'd2, 32'd12);
    rd_chk("R4 en lo", 4'd3, 32'h0000_0200);
    idle(2);
    rd_chk("R4 status after clear", 4'd7, 32'hFFFF_FFFF);
    check("R4 normal low", irq_norm_o, 0);

    // R2 direct enable words
    wr_reg(4'd4, 32'hA5A5_0001);
    rd_chk("R2 en hi", 4'd4, 32'hA5A5_0001);
    wr_reg(4'd3, 32'h0000_0000);
    rd_chk("R2 en lo", 4'd3, 32'h0);
    wr_reg(4'd6, 32'h0000_0001);
    rd_chk("R5 typ hi", 4'd6, 32'h0000_0001);
    src_i[32] = 1;
    idle(3);
    check("R5 source 32 fast", irq_fast_o, 1);

    // R10 write and source change in the same cycle
    wr_reg(4'd4, 32'h0);
    wr_reg(4'd5, 32'h0);
    src_i = '0;
    idle(3);
    @(negedge clk);
    src_i[20] = 1; reg_wr = 1; reg_addr = 4'd1; reg_wdata = 32'd20;
    @(negedge clk);
    reg_wr = 0; reg_addr = 4'd7; reg_wdata = '0;
    #1 check("R10 not yet visible", irq_norm_o, 0);
    @(negedge clk);
    #1 check("R10 visible after next edge", irq_norm_o, 1);
    check("R10 status", reg_rdata, 32'd20);

    // random traffic, compared every clock
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      src_i = {$urandom & $urandom, $urandom & $urandom};
      if ($urandom % 3 == 0) begin
        reg_wr = 1; reg_addr = 4'($urandom % 16); reg_wdata = $urandom;
      end else begin
        reg_wr = 0; reg_addr = 4'd7; reg_wdata = '0;
      end
    end
    @(negedge clk);
    reg_wr = 0; reg_addr = 4'd7;
    rd_chk("R2 en lo after random", 4'd3, en_word(0));
    rd_chk("R2 en hi after random", 4'd4, en_word(1));
    rd_chk("R5 typ lo after random", 4'd5, typ_word(0));
    rd_chk("R6 prio after random", 4'd12, pr_word(4));
    idle(3);
    finish_run();
  end
endmodule